// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the address for a four-beat burst access to a synchronous SRAM. An address strobe captures a full starting address. The two low bits of that address are the starting offset inside a four-word group, and the bits above them select the group. On each rising clock edge where the active-low advance input is sampled low, the low two address bits step to the next offset of the burst. Read bursts and write bursts use the same sequence, so the block has no direction input.

A static order input picks one of two sequences. In interleaved order the offset is the starting offset XORed with the beat count. In linear order the offset is the starting offset plus the beat count, modulo four. The output address is the held upper bits joined to the current offset. The upper bits never change during a burst, so a burst always wraps inside its four-word group.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, and before the first strobe, `addr_out` is all zeros.
- R2: When `strobe` is sampled high at a rising edge, `addr_out` equals the `addr_in` value sampled at that edge from the next cycle on, and the beat count goes back to zero.
- R3: When `strobe` and advance (`adv_n` low) are sampled together, the load wins: `addr_out` equals `addr_in` and the beat count is zero.
- R4: With `linear_mode` = 0 (interleaved), after k advances since the last strobe the low two bits of `addr_out` equal start XOR (k mod 4). For example, start 01 gives 01, 00, 11, 10.
- R5: With `linear_mode` = 1 (linear), after k advances since the last strobe the low two bits of `addr_out` equal (start + k) mod 4. For example, start 10 gives 10, 11, 00, 01.
- R6: An edge with `strobe` low and `adv_n` high leaves `addr_out` unchanged.
- R7: The advance after the fourth beat brings the offset back to the starting offset and does not carry into the upper bits, even when the upper bits are all ones.
- R8: Bits [ADDR_W-1:2] of `addr_out` stay constant across any number of advances while `strobe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe | input | 1 | Address strobe, active high, loads `addr_in` |
| adv_n | input | 1 | Advance, active low, steps to the next burst offset |
| linear_mode | input | 1 | Static order select: 0 interleaved, 1 linear |
| addr_in | input | ADDR_W | Starting address of the burst |
| addr_out | output | ADDR_W | Current burst address (held upper bits and current offset) |

## Verification
The bench builds the block with ADDR_W = 10. This leaves eight upper bits, enough to load both an all-ones group and a mixed pattern, so a carry out of the offset into the group bits would show up at the output. The bench runs every one of the four starting offsets in both orders through six advances, which covers the wrap after the fourth beat. It compares each beat with a reference worked out from the start value and the beat count.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam int OFFS_W = 2;

    typedef logic [OFFS_W-1:0] offset_t;

    typedef enum logic {
        ORD_INTERLEAVED = 1'b0,
        ORD_LINEAR      = 1'b1
    } order_e;

endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
    import burst_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    load,
    input  logic    step,
    output offset_t beat
);

    offset_t beat_d, beat_q;

    always_comb begin
        beat_d = beat_q;
        if (load) begin
            beat_d = '0;
        end else if (step) begin
            beat_d = beat_q + offset_t'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_q <= '0;
        end else begin
            beat_q <= beat_d;
        end
    end

    assign beat = beat_q;

    // R7: the fourth beat wraps to zero
    assert_beat_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && step && beat_q == 2'b11) |=> (beat_q == 2'b00));

    // R2: a load clears the beat count
    assert_load_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (beat_q == 2'b00));

endmodule

// File: rtl/burst_offset_map.sv
module burst_offset_map
    import burst_pkg::*;
(
    input  offset_t start,
    input  offset_t beat,
    input  order_e  order,
    output offset_t offset
);

    always_comb begin
        unique case (order)
            ORD_LINEAR:      offset = start + beat;
            ORD_INTERLEAVED: offset = start ^ beat;
            default:         offset = start;
        endcase
    end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic              adv_n,
    input  logic              linear_mode,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);

    localparam int UPPER_W = ADDR_W - OFFS_W;

    typedef struct packed {
        logic [UPPER_W-1:0] upper;
        offset_t            start;
    } hold_t;

    hold_t   st_d, st_q;
    offset_t beat;
    offset_t offset;
    logic    step;

    assign step = !adv_n;

    always_comb begin
        st_d = st_q;
        if (strobe) begin
            st_d.upper = addr_in[ADDR_W-1:OFFS_W];
            st_d.start = addr_in[OFFS_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    burst_beat_ctr i_beat (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (strobe),
        .step  (step),
        .beat  (beat)
    );

    burst_offset_map i_map (
        .start  (st_q.start),
        .beat   (beat),
        .order  (order_e'(linear_mode)),
        .offset (offset)
    );

    assign addr_out = {st_q.upper, offset};

    // R2, R3: a strobe loads the whole address, advance or not
    assert_load_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> (addr_out == $past(addr_in)));

    // R6: no strobe and no advance holds the address
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && adv_n) |=> $stable(addr_out));

    // R8: upper bits stay fixed while no strobe is seen
    assert_upper_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> (addr_out[ADDR_W-1:OFFS_W] == $past(addr_out[ADDR_W-1:OFFS_W])));

    // R5: linear order steps the offset by one
    assert_linear_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && !adv_n && linear_mode)
        |=> (addr_out[OFFS_W-1:0] == $past(addr_out[OFFS_W-1:0]) + 2'd1));

    // R4: interleaved order flips bit 0 on every step, bit 1 on every second
    assert_interleave_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && !adv_n && !linear_mode)
        |=> ((addr_out[OFFS_W-1:0] ^ $past(addr_out[OFFS_W-1:0])) inside {2'b01, 2'b11}));

endmodule

// File: tb/test_burst_addr_gen.sv
`timescale 1ns/1ps
module test_burst_addr_gen;

    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          strobe = 1'b0;
    logic          adv_n = 1'b1;
    logic          linear_mode = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] addr_out;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) i_burst_addr_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .strobe      (strobe),
        .adv_n       (adv_n),
        .linear_mode (linear_mode),
        .addr_in     (addr_in),
        .addr_out    (addr_out)
    );

    task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: addr_out=%h expected=%h", req, act, exp);
        end
    endtask

    // one edge with the given controls; sample 1 ns after the edge
    task automatic cycle(input logic s, input logic a_n, input logic [AW-1:0] a);
        strobe  = s;
        adv_n   = a_n;
        addr_in = a;
        @(posedge clk);
        #1;
        strobe = 1'b0;
        adv_n  = 1'b1;
    endtask

    function automatic logic [1:0] ref_off(input logic lin, input logic [1:0] st, input int k);
        logic [1:0] kk = 2'(k);
        return lin ? 2'(st + kk) : (st ^ kk);
    endfunction

    task automatic t_reset();
        #5;
        check("R1 reset", addr_out, '0);
        @(negedge clk);
        rst_n = 1'b1;
        cycle(1'b0, 1'b1, '0);
        check("R1 idle after reset", addr_out, '0);
    endtask

    task automatic t_sweep(input logic lin, input logic [AW-3:0] up);
        linear_mode = lin;
        for (int s = 0; s < 4; s++) begin
            logic [AW-1:0] a = {up, 2'(s)};
            cycle(1'b1, 1'b1, a);
            check("R2 load", addr_out, a);
            for (int k = 1; k <= 6; k++) begin
                cycle(1'b0, 1'b0, 10'h155);
                check(lin ? "R5 linear beat (R7 wrap, R8 upper)" : "R4 interleaved beat (R7 wrap, R8 upper)",
                      addr_out, {up, ref_off(lin, 2'(s), k)});
            end
        end
    endtask

    task automatic t_hold();
        logic [AW-1:0] a = {8'hA5, 2'b10};
        linear_mode = 1'b1;
        cycle(1'b1, 1'b1, a);
        cycle(1'b0, 1'b0, '0);
        for (int i = 0; i < 3; i++) begin
            cycle(1'b0, 1'b1, 10'h3FF);
            check("R6 hold without advance", addr_out, {8'hA5, 2'b11});
        end
        cycle(1'b0, 1'b0, '0);
        check("R6 resume after hold", addr_out, {8'hA5, 2'b00});
    endtask

    task automatic t_priority();
        logic [AW-1:0] a = {8'h3C, 2'b01};
        linear_mode = 1'b0;
        cycle(1'b1, 1'b1, {8'hFF, 2'b00});
        cycle(1'b0, 1'b0, '0);
        cycle(1'b0, 1'b0, '0);
        cycle(1'b1, 1'b0, a);
        check("R3 strobe beats advance", addr_out, a);
        cycle(1'b0, 1'b0, '0);
        check("R3 beat restarts at zero", addr_out, {8'h3C, 2'b00});
    endtask

    task automatic t_top_group();
        logic [AW-1:0] a = {8'hFF, 2'b11};
        linear_mode = 1'b1;
        cycle(1'b1, 1'b1, a);
        cycle(1'b0, 1'b0, '0);
        check("R7 no carry into upper bits", addr_out, {8'hFF, 2'b00});
        for (int i = 0; i < 3; i++) cycle(1'b0, 1'b0, '0);
        check("R7 wraps to start", addr_out, a);
    endtask

    initial begin
        t_reset();
        t_sweep(1'b0, 8'h5A);
        t_sweep(1'b1, 8'hC3);
        t_hold();
        t_priority();
        t_top_group();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule